// File: doc/BRIEF.md
# Register-Driven SMBus Byte-Data Master

This block lets software configure an image sensor over a two-wire bus. Each transfer moves a single byte. Software first sets up a configuration word. That word holds the enable, the left-justified 7-bit target ID, a clock divider, an acknowledge-mask option and two stored-only options. Software then writes a command word that packs the sensor register number, the write data and a read flag. That one write starts the transfer. The block then runs the whole bus sequence itself.

A write transfer sends START, the ID with W, the register byte, the data byte and STOP. A read transfer sends START, the ID with W and the register byte, then a repeated START. It then sends the ID with R, takes one byte back, answers it with NACK and sends STOP. The command word also reports the status: busy, read-valid and error. A completion flag raises a maskable interrupt, and software clears the flag by writing a one to it.

Both bus lines are open-drain. An output-enable set to 1 pulls the line low, and SDA is read back through its own input pin.

Top module: `smb_byte_master`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, and neither bus line is pulled low.
- R2: Register 0 (configuration) reads back:
  - bit 0: enable
  - bit 1: 16-bit mode (stored only)
  - bits 9:2: target ID, where bits 9:3 are the 7-bit address
  - bits 10+DIV_W-1:10: divider
  - bit 22: acknowledge mask
  - bit 23: compatibility option (stored only)
  
  All other bits read 0.
- R3: A write to register 1 with bit 24 clear starts a byte write of bits 7:0 to the sensor register in bits 23:16. The write produces exactly 28 SCL rising edges, and the target receives the data.
- R4: Register 1 bit 25 reads 1 from the cycle after the starting write until the transfer ends, then reads 0.
- R5: Every SCL low interval lasts exactly divider+1 clock cycles. The all-ones divider is therefore the slowest rate.
- R6: A write to register 1 with bit 24 set runs a read with a repeated START, 38 SCL rising edges in total. On success bit 26 is set and the byte returned by the target appears in bits 7:0.
- R7: If an address or data byte is not acknowledged and the mask is off, bit 27 (error) is set, bit 26 stays 0, and STOP follows at once.
- R8: With the acknowledge mask set, a byte that is not acknowledged causes no error and the full sequence runs.
- R9: Register 2 bit 0 sets when a transfer completes, and writing 1 there clears it. Register 3 bit 0 is the mask. `irq` follows the flag AND the mask.
- R10: A write to register 1 while a transfer is busy is ignored. It starts nothing and changes no stored field.
- R11: Clearing enable aborts a transfer to idle with both lines released and no completion flag. While enable is 0, a write to register 1 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and bus timing clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_addr` |
| irq | output | 1 | Completion interrupt |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The bench builds the block with DIV_W=4, so the divider spans only 0 to 15. This lets every divider value be swept, each with a write and a read-back against a behavioural target model, including the all-ones slowest setting. At each setting the bench measures the shortest and longest SCL low interval and counts SCL rising edges. A wrong target ID exercises the NACK and mask paths. A long transfer at divider 15 leaves time for ignored writes during busy and for the enable-clear abort.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // lines released
    ST_SETUP,  // both high before START
    ST_HOLD,   // SDA low, SCL high: START
    ST_BLO,    // bit, SCL low
    ST_BHI,    // bit, SCL high
    ST_RLO,    // repeated start, SCL low
    ST_RHI,    // repeated start, SCL high
    ST_PLO,    // stop, SCL low, SDA low
    ST_PHI,    // stop, SCL high, SDA low
    ST_PEND    // stop, SDA released
  } smb_state_e;

  localparam logic [1:0] RIX_CFG  = 2'd0;
  localparam logic [1:0] RIX_CMD  = 2'd1;
  localparam logic [1:0] RIX_FLAG = 2'd2;
  localparam logic [1:0] RIX_MASK = 2'd3;

  localparam int CMD_RD_BIT   = 24;
  localparam int CMD_BUSY_BIT = 25;
  localparam int CMD_RVAL_BIT = 26;
  localparam int CMD_ERR_BIT  = 27;
  localparam int CFG_DIV_LSB  = 10;
  localparam int CFG_AMSK_BIT = 22;
  localparam int CFG_COMP_BIT = 23;
endpackage

// File: rtl/smb_tick.sv
module smb_tick #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run || cnt_q == '0) begin
      cnt_q <= div;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             rd,
  input  logic [6:0]       dev,
  input  logic [7:0]       regno,
  input  logic [7:0]       wbyte,
  input  logic             ack_mask,
  input  logic [DIV_W-1:0] div,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [7:0]       rbyte
);
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [1:0] IDX_RX   = 2'd3;

  smb_state_e  state_q;
  logic [3:0]  bit_q;
  logic [1:0]  idx_q;
  logic [7:0]  sh_q, rx_q, reg_q, wb_q;
  logic [6:0]  dev_q;
  logic        rd_q, err_q, done_q, tick;

  smb_tick #(.DIV_W(DIV_W)) i_tick (
    .clk (clk),
    .rst (rst),
    .run (state_q != ST_IDLE),
    .div (div),
    .tick(tick)
  );

  function automatic logic [7:0] byte_for(input logic [1:0] idx, input logic rdf,
                                          input logic [6:0] d, input logic [7:0] r,
                                          input logic [7:0] w);
    case (idx)
      2'd0:    byte_for = {d, 1'b0};
      2'd1:    byte_for = r;
      2'd2:    byte_for = rdf ? {d, 1'b1} : w;
      default: byte_for = 8'hFF;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      idx_q   <= '0;
      sh_q    <= 8'hFF;
      rx_q    <= '0;
      reg_q   <= '0;
      wb_q    <= '0;
      dev_q   <= '0;
      rd_q    <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: if (start) begin
            state_q <= ST_SETUP;
            rd_q    <= rd;
            dev_q   <= dev;
            reg_q   <= regno;
            wb_q    <= wbyte;
            idx_q   <= '0;
            bit_q   <= '0;
            err_q   <= 1'b0;
          end
          ST_SETUP: if (tick) state_q <= ST_HOLD;
          ST_HOLD: if (tick) begin
            state_q <= ST_BLO;
            bit_q   <= '0;
            sh_q    <= byte_for(idx_q, rd_q, dev_q, reg_q, wb_q);
          end
          ST_BLO: if (tick) state_q <= ST_BHI;
          ST_BHI: if (tick) begin
            if (bit_q != ACK_SLOT) begin
              bit_q   <= bit_q + 1'b1;
              sh_q    <= {sh_q[6:0], 1'b1};
              if (idx_q == IDX_RX) rx_q <= {rx_q[6:0], sda_in};
              state_q <= ST_BLO;
            end else if (idx_q != IDX_RX && sda_in && !ack_mask) begin
              err_q   <= 1'b1;
              state_q <= ST_PLO;
            end else if (idx_q == IDX_RX || (idx_q == 2'd2 && !rd_q)) begin
              state_q <= ST_PLO;
            end else if (idx_q == 2'd1 && rd_q) begin
              idx_q   <= 2'd2;
              state_q <= ST_RLO;
            end else begin
              idx_q   <= idx_q + 1'b1;
              bit_q   <= '0;
              sh_q    <= byte_for(idx_q + 1'b1, rd_q, dev_q, reg_q, wb_q);
              state_q <= ST_BLO;
            end
          end
          ST_RLO: if (tick) state_q <= ST_RHI;
          ST_RHI: if (tick) state_q <= ST_HOLD;
          ST_PLO: if (tick) state_q <= ST_PHI;
          ST_PHI: if (tick) state_q <= ST_PEND;
          ST_PEND: if (tick) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // Line drive is a decode of registered state only.
  always_comb begin
    scl_oe = (state_q == ST_BLO) || (state_q == ST_RLO) || (state_q == ST_PLO);
    sda_oe = (state_q == ST_HOLD) || (state_q == ST_PLO) || (state_q == ST_PHI) ||
             (((state_q == ST_BLO) || (state_q == ST_BHI)) &&
              (bit_q != ACK_SLOT) && !sh_q[7]);
  end

  assign busy  = (state_q != ST_IDLE);
  assign done  = done_q;
  assign err   = err_q;
  assign rbyte = rx_q;
endmodule

// File: rtl/smb_byte_master.sv
module smb_byte_master
  import smb_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  // Divider field must end below the mask bit (DIV_W <= 12).
  localparam int DIV_MSB = CFG_DIV_LSB + DIV_W - 1;

  logic             en_q, mode_q, amask_q, comp_q;
  logic [7:0]       tid_q;
  logic [DIV_W-1:0] div_q;
  logic [15:0]      data_q;
  logic [7:0]       raddr_q;
  logic             rd_q, rvalid_q, err_q, flag_q, mask_q, irq_q;
  logic             eng_busy, eng_done, eng_err;
  logic [7:0]       eng_rbyte;
  logic             cmd_wr, start;
  logic [31:0]      rd_mux;
  logic             unused_bits;

  assign cmd_wr = reg_we && (reg_addr == RIX_CMD);
  assign start  = cmd_wr && en_q && !eng_busy;

  smb_engine #(.DIV_W(DIV_W)) i_eng (
    .clk     (clk),
    .rst     (rst),
    .en      (en_q),
    .start   (start),
    .rd      (reg_wdata[CMD_RD_BIT]),
    .dev     (tid_q[7:1]),
    .regno   (reg_wdata[23:16]),
    .wbyte   (reg_wdata[7:0]),
    .ack_mask(amask_q),
    .div     (div_q),
    .sda_in  (sda_in),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .busy    (eng_busy),
    .done    (eng_done),
    .err     (eng_err),
    .rbyte   (eng_rbyte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; mode_q <= 1'b0; amask_q <= 1'b0; comp_q <= 1'b0;
      tid_q <= '0; div_q <= '0;
      data_q <= '0; raddr_q <= '0; rd_q <= 1'b0;
      rvalid_q <= 1'b0; err_q <= 1'b0;
      flag_q <= 1'b0; mask_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RIX_CFG: begin
            en_q    <= reg_wdata[0];
            mode_q  <= reg_wdata[1];
            tid_q   <= reg_wdata[9:2];
            div_q   <= reg_wdata[DIV_MSB:CFG_DIV_LSB];
            amask_q <= reg_wdata[CFG_AMSK_BIT];
            comp_q  <= reg_wdata[CFG_COMP_BIT];
          end
          RIX_CMD: if (!eng_busy) begin
            data_q  <= reg_wdata[15:0];
            raddr_q <= reg_wdata[23:16];
            rd_q    <= reg_wdata[CMD_RD_BIT];
            if (en_q) begin
              rvalid_q <= 1'b0;
              err_q    <= 1'b0;
            end
          end
          RIX_FLAG: if (reg_wdata[0]) flag_q <= 1'b0;
          default:  mask_q <= reg_wdata[0];
        endcase
      end
      if (eng_done) begin
        flag_q   <= 1'b1;
        err_q    <= eng_err;
        rvalid_q <= rd_q && !eng_err;
        if (rd_q && !eng_err) data_q[7:0] <= eng_rbyte;
      end
      irq_q <= flag_q && mask_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RIX_CFG: begin
        rd_mux[0]                   = en_q;
        rd_mux[1]                   = mode_q;
        rd_mux[9:2]                 = tid_q;
        rd_mux[DIV_MSB:CFG_DIV_LSB] = div_q;
        rd_mux[CFG_AMSK_BIT]        = amask_q;
        rd_mux[CFG_COMP_BIT]        = comp_q;
      end
      RIX_CMD: begin
        rd_mux[15:0]         = data_q;
        rd_mux[23:16]        = raddr_q;
        rd_mux[CMD_RD_BIT]   = rd_q;
        rd_mux[CMD_BUSY_BIT] = eng_busy;
        rd_mux[CMD_RVAL_BIT] = rvalid_q;
        rd_mux[CMD_ERR_BIT]  = err_q;
      end
      RIX_FLAG: rd_mux[0] = flag_q;
      default:  rd_mux[0] = mask_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign irq         = irq_q;
  assign unused_bits = ^{reg_wdata[31:28], reg_wdata[21:DIV_MSB+1]};
endmodule

// File: rtl/smb_byte_master_chk.sv
module smb_byte_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_q,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       err_q,
  input logic       rvalid_q,
  input logic       eng_done,
  input logic       flag_q,
  input logic       start,
  input logic       eng_busy,
  input logic       cmd_wr,
  input logic [7:0] raddr_q
);
  // R11: two cycles with enable clear leave both lines released
  a_r11_disabled_released: assert property (@(posedge clk) disable iff (rst)
    (!en_q && $past(!en_q)) |-> (!scl_oe && !sda_oe));

  // R7: error and read-valid never reported together
  a_r7_err_excludes_rvalid: assert property (@(posedge clk) disable iff (rst)
    !(err_q && rvalid_q));

  // R9: engine completion raises the flag
  a_r9_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> flag_q);

  // R4: an accepted start makes the engine busy
  a_r4_start_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> eng_busy);

  // R10: command write during busy leaves the register field alone
  a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && cmd_wr) |=> $stable(raddr_q));
endmodule

bind smb_byte_master smb_byte_master_chk i_chk (
  .clk     (clk),
  .rst     (rst),
  .en_q    (en_q),
  .scl_oe  (scl_oe),
  .sda_oe  (sda_oe),
  .err_q   (err_q),
  .rvalid_q(rvalid_q),
  .eng_done(eng_done),
  .flag_q  (flag_q),
  .start   (start),
  .eng_busy(eng_busy),
  .cmd_wr  (cmd_wr),
  .raddr_q (raddr_q)
);

// File: tb/test_smb_byte_master.sv
`timescale 1ns/1ps
module test_smb_byte_master;
  localparam int DIVW = 4;
  localparam logic [6:0] SLV = 7'h21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic s_drive, s_clr, mon_clr;
  wire  scl_w = !scl_oe;
  wire  sda_w = !(sda_oe || s_drive);

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  smb_byte_master #(.DIV_W(DIVW)) i_smb_byte_master (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w)
  );

  // ---------------- target model ----------------
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic scl_p, sda_p, first;
  logic [3:0] cnt;
  logic [1:0] phase;  // 0 idle, 1 addr, 2 data, 3 read
  logic [7:0] shreg, ptr, rbuf;

  always @(posedge clk) begin
    scl_p <= scl_w;
    sda_p <= sda_w;
    if (rst || s_clr) begin
      phase <= 2'd0; cnt <= '0; s_drive <= 1'b0; first <= 1'b0;
      shreg <= '0; rbuf <= '0;
      if (rst) begin
        ptr <= '0;
        for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
      end
    end else if (scl_p && scl_w && sda_p && !sda_w) begin
      phase <= 2'd1; cnt <= '0; s_drive <= 1'b0;
    end else if (scl_p && scl_w && !sda_p && sda_w) begin
      phase <= 2'd0; s_drive <= 1'b0;
    end else if (!scl_p && scl_w) begin
      if (phase != 2'd0) begin
        if (cnt < 4'd8 && phase != 2'd3) shreg <= {shreg[6:0], sda_w};
        cnt <= cnt + 1'b1;
      end
    end else if (scl_p && !scl_w) begin
      case (phase)
        2'd1: begin
          if (cnt == 4'd8) begin
            if (shreg[7:1] == SLV) s_drive <= 1'b1;
          end else if (cnt == 4'd9) begin
            s_drive <= 1'b0; cnt <= '0;
            if (shreg[7:1] != SLV) phase <= 2'd0;
            else if (shreg[0]) begin
              phase <= 2'd3; rbuf <= mem[ptr]; s_drive <= !mem[ptr][7];
            end else begin
              phase <= 2'd2; first <= 1'b1;
            end
          end
        end
        2'd2: begin
          if (cnt == 4'd8) begin
            s_drive <= 1'b1;
            if (first) ptr <= shreg; else mem[ptr] <= shreg;
            first <= 1'b0;
          end else if (cnt == 4'd9) begin
            s_drive <= 1'b0; cnt <= '0;
          end
        end
        2'd3: begin
          if (cnt >= 4'd1 && cnt <= 4'd7) s_drive <= !rbuf[3'(4'd7 - cnt)];
          else if (cnt == 4'd8) s_drive <= 1'b0;
          else if (cnt == 4'd9) begin cnt <= '0; phase <= 2'd0; end
        end
        default: ;
      endcase
    end
  end

  // ---------------- line monitor ----------------
  int rises, lo_run, lo_min, lo_max;
  always @(posedge clk) begin
    if (mon_clr) begin
      rises <= 0; lo_run <= 0; lo_min <= 1000000; lo_max <= 0;
    end else begin
      if (!scl_p && scl_w) rises <= rises + 1;
      if (!scl_w) lo_run <= lo_run + 1;
      else if (lo_run > 0) begin
        if (lo_run < lo_min) lo_min <= lo_run;
        if (lo_run > lo_max) lo_max <= lo_run;
        lo_run <= 0;
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic wait_idle(output logic [31:0] st);
    for (int k = 0; k < 20000; k++) begin
      reg_read(2'd1, st);
      if (!st[25]) break;
    end
  endtask

  function automatic logic [31:0] cfg(input logic en, input logic [6:0] a,
                                      input logic [3:0] dv, input logic am);
    cfg = 32'(en) | (32'({a, 1'b0}) << 2) | (32'(dv) << 10) | (32'(am) << 22);
  endfunction

  task automatic xfer(input logic rd, input logic [7:0] r, input logic [7:0] d,
                      output logic [31:0] st);
    clear_mon();
    reg_write(2'd1, {7'd0, rd, r, 8'd0, d});
    wait_idle(st);
  endtask

  logic [31:0] v, st;

  initial begin
    s_clr = 1'b0; mon_clr = 1'b1;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'hA5;
    repeat (4) @(negedge clk);
    rst = 1'b0; mon_clr = 1'b0;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), v);
      chk("R1 reset register", v, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    chk("R1 reset lines", {30'd0, scl_oe, sda_oe}, 32'd0);

    // R2 configuration readback
    reg_write(2'd0, 32'hFFFF_FFFF);
    reg_read(2'd0, v);
    chk("R2 cfg all ones", v, 32'h00C0_3FFF);
    reg_write(2'd0, cfg(1'b1, SLV, 4'd5, 1'b0) | 32'h2);
    reg_read(2'd0, v);
    chk("R2 cfg fields", v, cfg(1'b1, SLV, 4'd5, 1'b0) | 32'h2);

    // R3/R4/R5/R6: sweep every divider with a write and a read-back
    for (int dv = 0; dv < 16; dv++) begin
      logic [7:0] r, d;
      r = 8'(dv * 16 + 5);
      d = 8'(dv * 37 + 11);
      reg_write(2'd0, cfg(1'b1, SLV, 4'(dv), 1'b0));
      clear_mon();
      reg_write(2'd1, {8'd0, r, 8'd0, d});
      reg_read(2'd1, v);
      chk("R4 busy during write", {31'd0, v[25]}, 32'd1);
      wait_idle(st);
      exp_mem[r] = d;
      chk("R3 write status", {28'd0, st[27:24]}, 32'd0);
      chk("R3 target received", {24'd0, mem[r]}, {24'd0, d});
      chk("R3 write scl edges", 32'(rises), 32'd28);
      chk("R5 low min", 32'(lo_min), 32'(dv + 1));
      chk("R5 low max", 32'(lo_max), 32'(dv + 1));
      xfer(1'b1, r, 8'h00, st);
      chk("R6 read status", {28'd0, st[27:24]}, 32'b0101);
      chk("R6 read data", {24'd0, st[7:0]}, {24'd0, exp_mem[r]});
      chk("R6 read scl edges", 32'(rises), 32'd38);
      chk("R5 read low max", 32'(lo_max), 32'(dv + 1));
    end

    // R6 read of an untouched register
    reg_write(2'd0, cfg(1'b1, SLV, 4'd1, 1'b0));
    xfer(1'b1, 8'h3C, 8'h00, st);
    chk("R6 untouched read", {24'd0, st[7:0]}, {24'd0, exp_mem[8'h3C]});

    // R9 flag and mask
    reg_read(2'd2, v);
    chk("R9 flag set", v, 32'd1);
    chk("R9 masked irq", {31'd0, irq}, 32'd0);
    reg_write(2'd3, 32'd1);
    @(negedge clk);
    chk("R9 unmasked irq", {31'd0, irq}, 32'd1);
    reg_write(2'd2, 32'd0);
    reg_read(2'd2, v);
    chk("R9 write zero keeps flag", v, 32'd1);
    reg_write(2'd2, 32'd1);
    reg_read(2'd2, v);
    chk("R9 w1c clears flag", v, 32'd0);
    chk("R9 irq drops", {31'd0, irq}, 32'd0);

    // R7 wrong target, no mask
    reg_write(2'd0, cfg(1'b1, 7'h22, 4'd1, 1'b0));
    xfer(1'b0, 8'h10, 8'h77, st);
    chk("R7 write nack error", {28'd0, st[27:24]}, 32'b1000);
    chk("R7 stop after address", 32'(rises), 32'd10);
    xfer(1'b1, 8'h10, 8'h00, st);
    chk("R7 read nack error", {28'd0, st[27:24]}, 32'b1001);

    // R8 wrong target with mask
    reg_write(2'd0, cfg(1'b1, 7'h22, 4'd1, 1'b1));
    xfer(1'b0, 8'h11, 8'h66, st);
    chk("R8 masked no error", {28'd0, st[27:24]}, 32'd0);
    chk("R8 full sequence", 32'(rises), 32'd28);
    chk("R8 target untouched", {24'd0, mem[8'h11]}, {24'd0, exp_mem[8'h11]});

    // R10 command write while busy
    reg_write(2'd0, cfg(1'b1, SLV, 4'd15, 1'b0));
    clear_mon();
    reg_write(2'd1, {8'd0, 8'h40, 8'd0, 8'h9C});
    repeat (20) @(negedge clk);
    reg_write(2'd1, {8'd0, 8'hEE, 8'd0, 8'h5A});
    wait_idle(st);
    exp_mem[8'h40] = 8'h9C;
    chk("R10 field kept", {24'd0, st[23:16]}, 32'h40);
    chk("R10 data kept", {16'd0, st[15:0]}, 32'h9C);
    chk("R10 second reg untouched", {24'd0, mem[8'hEE]}, {24'd0, exp_mem[8'hEE]});
    chk("R10 one transfer only", 32'(rises), 32'd28);

    // R11 abort by enable clear
    reg_write(2'd2, 32'd1);
    reg_write(2'd1, {8'd0, 8'h50, 8'd0, 8'h33});
    repeat (100) @(negedge clk);
    reg_write(2'd0, cfg(1'b0, SLV, 4'd15, 1'b0));
    @(negedge clk);
    chk("R11 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
    reg_read(2'd1, v);
    chk("R11 not busy", {31'd0, v[25]}, 32'd0);
    reg_read(2'd2, v);
    chk("R11 no completion flag", v, 32'd0);
    @(negedge clk); s_clr = 1'b1;
    @(negedge clk); s_clr = 1'b0;
    clear_mon();
    reg_write(2'd1, {8'd0, 8'h51, 8'd0, 8'h44});
    repeat (200) @(negedge clk);
    chk("R11 disabled start blocked", 32'(rises), 32'd0);
    reg_read(2'd1, v);
    chk("R11 disabled not busy", {31'd0, v[25]}, 32'd0);

    // re-enable and confirm normal operation resumes
    reg_write(2'd0, cfg(1'b1, SLV, 4'd2, 1'b0));
    xfer(1'b1, 8'h40, 8'h00, st);
    chk("R6 read after abort", {24'd0, st[7:0]}, 32'h9C);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule